// File: doc/BRIEF.md
# Memory Bridge Address Range Checker

This block sits on the command path between an on-chip requester port and a DRAM controller. It screens every read and write command against the span of memory that is actually attached. Two 5-bit size indices set that span. A memory index M describes attached memory of 2^M granules starting at address zero. A region index describes the address window that the system has mapped to the bridge. When inline ECC is enabled, only eight ninths of the attached memory is usable.

A command is flagged only when the mapped region is larger than the attached memory and the command address lies beyond the usable limit. A flagged write is absorbed and never reaches memory, and the block answers it locally with an error write response. A flagged read still goes to memory. Every data beat that comes back for it is replaced with zeros and marked with an error. The tag the read was issued with identifies its data, so the rule holds when responses return out of order.

The first violation sets a sticky status bit and captures the address and route ID of the offending command. The status bit drives an interrupt level through an enable. Software clears the bit by writing 1, and that write also re-arms the capture.

Top module: `mem_addr_guard`

## Requirements
- R1: `cfg_ctrl[9:5]` is the memory index M and `cfg_ctrl[4:0]` is the region index. When the region index is less than or equal to M, no command is ever flagged, whatever its address.
- R2: When the region index exceeds M and `ecc_en` is 0, a command is flagged exactly when its address is at least 2^(M+GRAN_W).
- R3: When the region index exceeds M and `ecc_en` is 1, a command is flagged exactly when 9 × address is at least 8 × 2^(M+GRAN_W). This limit applies to every address.
- R4: A flagged write (`cmd_write`=1) is never presented on `mem_valid`, and `cmd_ready` is 1 in that cycle. In the next cycle `wr_rsp_valid`=1, `wr_rsp_err`=1 and `wr_rsp_tag` equals the command tag, and `mem_wr_rsp_ready`=0.
- R5: A command that is not flagged appears on `mem_*` with the same write flag, address, ID and tag, and `cmd_ready` follows `mem_ready`. Memory write responses pass through with `wr_rsp_err`=0.
- R6: A flagged read is forwarded to memory. Every `mem_rd_*` beat whose tag matches that read is returned with `rd_rsp_data`=0 and `rd_rsp_err`=1. Beats for reads that were not flagged pass unchanged with `rd_rsp_err`=0, even when the beats arrive out of order.
- R7: A flagged command that is accepted sets `int_raw[1]` from the next cycle on. The bit stays set until a cycle with `aerr_clr`=1 and no new violation. `int_raw[0]` is always 0.
- R8: `irq` equals `int_raw[1]` AND `irq_en`.
- R9: `log_addr` and `log_id` capture the address and route ID of a violation that is accepted while `int_raw[1]` is 0, or in a cycle with `aerr_clr`=1. Later violations leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 10 | Size indices: memory [9:5], region [4:0] |
| ecc_en | input | 1 | Inline ECC active, limit reduced to 8/9 |
| irq_en | input | 1 | Interrupt enable |
| aerr_clr | input | 1 | Write-1 clear of the sticky error bit |
| cmd_valid | input | 1 | Requester command valid |
| cmd_ready | output | 1 | Command accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command byte address |
| cmd_id | input | ID_W | Requester route ID |
| cmd_tag | input | TAG_W | Transaction tag |
| mem_valid | output | 1 | Command to memory valid |
| mem_ready | input | 1 | Memory accepts command |
| mem_write | output | 1 | Forwarded write flag |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_id | output | ID_W | Forwarded route ID |
| mem_tag | output | TAG_W | Forwarded tag |
| mem_wr_rsp_valid | input | 1 | Memory write response valid |
| mem_wr_rsp_ready | output | 1 | Memory write response taken |
| mem_wr_rsp_tag | input | TAG_W | Memory write response tag |
| wr_rsp_valid | output | 1 | Write response to requester |
| wr_rsp_tag | output | TAG_W | Write response tag |
| wr_rsp_err | output | 1 | Write response error status |
| mem_rd_valid | input | 1 | Memory read beat valid |
| mem_rd_tag | input | TAG_W | Memory read beat tag |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_rd_last | input | 1 | Last beat of the burst |
| rd_rsp_valid | output | 1 | Read beat to requester |
| rd_rsp_tag | output | TAG_W | Read beat tag |
| rd_rsp_data | output | DATA_W | Read data, zero when flagged |
| rd_rsp_last | output | 1 | Last beat of the burst |
| rd_rsp_err | output | 1 | Read error status |
| int_raw | output | 2 | Raw status, bit 1 = address error |
| irq | output | 1 | Error interrupt level |
| log_addr | output | ADDR_W | Captured faulting address |
| log_id | output | ID_W | Captured faulting route ID |

## Verification
The bench builds the block with ADDR_W=16, GRAN_W=4, ID_W=4, TAG_W=3 and DATA_W=16. With these values a memory index of 8 places the plain limit at 4096 and the ECC-reduced limit between 3640 and 3641. Both boundaries, and addresses far beyond them, can then be reached with 16-bit addresses. The 3-bit tag keeps the read tracker at eight entries, so two reads with different tags can be issued and their data returned in reverse order.

// File: rtl/mag_pkg.sv
// Shared constants for the memory bridge address range checker.
// Assumes the control word layout that software programs: memory size
// index in the upper field, region size index in the lower field.
package mag_pkg;
    localparam int IDX_W    = 5;
    localparam int CTRL_W   = 2 * IDX_W;
    localparam int RGN_LSB  = 0;
    localparam int MEM_LSB  = IDX_W;
    localparam int ECC_MUL  = 9;   // ECC limit: 9*addr compared with 8*size
    localparam int ECC_SH   = 3;   // log2 of the 8 in 8/9
    typedef logic [IDX_W-1:0] size_idx_t;
endpackage

// File: rtl/mag_range_check.sv
// Combinational address screen.
// Decides whether one command address lies outside the usable memory.
// The attached memory is 2^(M+GRAN_W) bytes from address zero, and is
// reduced to 8/9 of that when inline ECC is on. A violation is reported
// only when the region index exceeds M.
// Assumes the configuration is static while commands are in flight.
module mag_range_check
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              ecc_en,
    output logic              viol
);
    localparam int SW = ADDR_W + 4;

    size_idx_t      mem_idx;
    size_idx_t      rgn_idx;
    logic [SW-1:0]  wide;
    logic [SW-1:0]  scaled;
    logic [7:0]     shamt;
    logic           beyond;

    // Field decode, scale by nine under ECC, shift out the usable span.
    always_comb begin
        mem_idx = cfg_ctrl[MEM_LSB +: IDX_W];
        rgn_idx = cfg_ctrl[RGN_LSB +: IDX_W];
        wide    = SW'(addr);
        scaled  = ecc_en ? ((wide << ECC_SH) + wide) : wide;
        shamt   = 8'(mem_idx) + 8'(GRAN_W) + (ecc_en ? 8'(ECC_SH) : 8'd0);
        beyond  = (scaled >> shamt) != '0;
        viol    = (rgn_idx > mem_idx) && beyond;
    end
endmodule

// File: rtl/mag_err_log.sv
// Sticky address-error status with first-error capture.
// The status bit is set on any accepted violation and is cleared by a
// write-1 pulse. A violation in the same cycle as the clear wins.
// The address and ID are captured only while the bit is clear or is
// being cleared, so the first error stays logged.
module mag_err_log #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              clr,
    input  logic              irq_en,
    output logic              raw,
    output logic              irq,
    output logic [ADDR_W-1:0] log_addr,
    output logic [ID_W-1:0]   log_id
);
    // Status bit and log register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw      <= 1'b0;
            log_addr <= '0;
            log_id   <= '0;
        end else begin
            if (err_evt)
                raw <= 1'b1;
            else if (clr)
                raw <= 1'b0;
            if (err_evt && (!raw || clr)) begin
                log_addr <= evt_addr;
                log_id   <= evt_id;
            end
        end
    end

    // Interrupt level gated by the enable.
    always_comb irq = raw && irq_en;

    p_set_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> raw);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr) |=> raw);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw && !err_evt) |=> !raw);
    p_log_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr) |=> ($stable(log_addr) && $stable(log_id)));
endmodule

// File: rtl/mag_rd_tracker.sv
// Per-tag read error tracker.
// Records for each tag whether the read last issued with it was flagged.
// Returning beats with that tag are then zeroed and marked as errors.
// Assumes a tag is not reused while a read carrying it is outstanding.
module mag_rd_tracker #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              issue_bad,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_err
);
    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0] bad_flag;

    // Remember the verdict of each issued read by its tag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_flag <= '0;
        else if (issue)
            bad_flag[issue_tag] <= issue_bad;
    end

    // Apply the recorded verdict to the returning beat.
    always_comb begin
        out_valid = in_valid;
        out_tag   = in_tag;
        out_last  = in_last;
        out_err   = in_valid && bad_flag[in_tag];
        out_data  = out_err ? '0 : in_data;
    end

    p_zero_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_data == '0));
endmodule

// File: rtl/mem_addr_guard.sv
// Top of the memory bridge address range checker.
// Commands that are not flagged pass straight through to memory. A
// flagged write is absorbed and answered one cycle later with an error
// response, which takes priority over memory write responses. A flagged
// read is forwarded and its data is zeroed on return.
// Assumes the requester always accepts responses.
module mem_addr_guard
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN_W = 20,
    parameter int ID_W   = 8,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              ecc_en,
    input  logic              irq_en,
    input  logic              aerr_clr,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ID_W-1:0]   mem_id,
    output logic [TAG_W-1:0]  mem_tag,
    input  logic              mem_wr_rsp_valid,
    output logic              mem_wr_rsp_ready,
    input  logic [TAG_W-1:0]  mem_wr_rsp_tag,
    output logic              wr_rsp_valid,
    output logic [TAG_W-1:0]  wr_rsp_tag,
    output logic              wr_rsp_err,
    input  logic              mem_rd_valid,
    input  logic [TAG_W-1:0]  mem_rd_tag,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_last,
    output logic              rd_rsp_valid,
    output logic [TAG_W-1:0]  rd_rsp_tag,
    output logic [DATA_W-1:0] rd_rsp_data,
    output logic              rd_rsp_last,
    output logic              rd_rsp_err,
    output logic [1:0]        int_raw,
    output logic              irq,
    output logic [ADDR_W-1:0] log_addr,
    output logic [ID_W-1:0]   log_id
);
    logic             viol;
    logic             bad_wr_acc;
    logic             rd_issue;
    logic             err_evt;
    logic             aerr_raw;
    logic             loc_v;
    logic [TAG_W-1:0] loc_tag;

    mag_range_check #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_chk (
        .addr     (cmd_addr),
        .cfg_ctrl (cfg_ctrl),
        .ecc_en   (ecc_en),
        .viol     (viol)
    );

    // Command steering: absorb flagged writes, pass everything else.
    always_comb begin
        bad_wr_acc = cmd_valid && cmd_write && viol;
        mem_valid  = cmd_valid && !(cmd_write && viol);
        cmd_ready  = (cmd_write && viol) ? 1'b1 : mem_ready;
        mem_write  = cmd_write;
        mem_addr   = cmd_addr;
        mem_id     = cmd_id;
        mem_tag    = cmd_tag;
        rd_issue   = cmd_valid && !cmd_write && mem_ready;
        err_evt    = bad_wr_acc || (rd_issue && viol);
    end

    // Local error response for an absorbed write, one cycle after accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_v   <= 1'b0;
            loc_tag <= '0;
        end else begin
            loc_v <= bad_wr_acc;
            if (bad_wr_acc)
                loc_tag <= cmd_tag;
        end
    end

    // Write response merge: the local error response goes first.
    always_comb begin
        mem_wr_rsp_ready = !loc_v;
        wr_rsp_valid     = loc_v || mem_wr_rsp_valid;
        wr_rsp_tag       = loc_v ? loc_tag : mem_wr_rsp_tag;
        wr_rsp_err       = loc_v;
    end

    mag_rd_tracker #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (rd_issue),
        .issue_tag (cmd_tag),
        .issue_bad (viol),
        .in_valid  (mem_rd_valid),
        .in_tag    (mem_rd_tag),
        .in_data   (mem_rd_data),
        .in_last   (mem_rd_last),
        .out_valid (rd_rsp_valid),
        .out_tag   (rd_rsp_tag),
        .out_data  (rd_rsp_data),
        .out_last  (rd_rsp_last),
        .out_err   (rd_rsp_err)
    );

    mag_err_log #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_evt  (err_evt),
        .evt_addr (cmd_addr),
        .evt_id   (cmd_id),
        .clr      (aerr_clr),
        .irq_en   (irq_en),
        .raw      (aerr_raw),
        .irq      (irq),
        .log_addr (log_addr),
        .log_id   (log_id)
    );

    // Raw status word: bit 1 is the address error, bit 0 is unused.
    always_comb int_raw = {aerr_raw, 1'b0};

    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr_acc |-> !mem_valid);
    p_drop_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr_acc |=> (wr_rsp_valid && wr_rsp_err && wr_rsp_tag == $past(cmd_tag)));
    p_quiet_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[RGN_LSB +: IDX_W] <= cfg_ctrl[MEM_LSB +: IDX_W]) |-> !err_evt);
endmodule

// File: tb/sim_mem_addr_guard.sv
module sim_mem_addr_guard;
    localparam int AW = 16, GW = 4, IW = 4, TW = 3, DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [9:0] cfg_ctrl = '0;
    logic ecc_en = 0, irq_en = 0, aerr_clr = 0;
    logic cmd_valid = 0, cmd_write = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [IW-1:0] cmd_id = '0;
    logic [TW-1:0] cmd_tag = '0;
    logic mem_ready = 0, mem_wr_rsp_valid = 0;
    logic [TW-1:0] mem_wr_rsp_tag = '0, mem_rd_tag = '0;
    logic mem_rd_valid = 0, mem_rd_last = 0;
    logic [DW-1:0] mem_rd_data = '0;
    logic cmd_ready, mem_valid, mem_write, mem_wr_rsp_ready;
    logic [AW-1:0] mem_addr, log_addr;
    logic [IW-1:0] mem_id, log_id;
    logic [TW-1:0] mem_tag, wr_rsp_tag, rd_rsp_tag;
    logic wr_rsp_valid, wr_rsp_err, rd_rsp_valid, rd_rsp_last, rd_rsp_err, irq;
    logic [DW-1:0] rd_rsp_data;
    logic [1:0] int_raw;

    int checks = 0, errors = 0;
    logic got_mv, got_cr;
    logic [AW-1:0] got_ma;
    bit done = 0;

    always #10 clk = ~clk;

    mem_addr_guard #(.ADDR_W(AW), .GRAN_W(GW), .ID_W(IW), .TAG_W(TW), .DATA_W(DW)) u0 (
        .clk, .rst_n, .cfg_ctrl, .ecc_en, .irq_en, .aerr_clr,
        .cmd_valid, .cmd_ready, .cmd_write, .cmd_addr, .cmd_id, .cmd_tag,
        .mem_valid, .mem_ready, .mem_write, .mem_addr, .mem_id, .mem_tag,
        .mem_wr_rsp_valid, .mem_wr_rsp_ready, .mem_wr_rsp_tag,
        .wr_rsp_valid, .wr_rsp_tag, .wr_rsp_err,
        .mem_rd_valid, .mem_rd_tag, .mem_rd_data, .mem_rd_last,
        .rd_rsp_valid, .rd_rsp_tag, .rd_rsp_data, .rd_rsp_last, .rd_rsp_err,
        .int_raw, .irq, .log_addr, .log_id);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected verdict computed from the requirement text.
    function automatic bit exp_bad(input longint a, input int mi, input int ri, input bit ecc);
        longint size = longint'(1) << (mi + GW);
        if (ri <= mi) return 0;
        if (ecc) return (9 * a) >= (8 * size);
        return a >= size;
    endfunction

    task automatic set_cfg(input int mi, input int ri, input bit ecc);
        @(negedge clk);
        cfg_ctrl = {5'(mi), 5'(ri)};
        ecc_en = ecc;
    endtask

    // Present one command for one cycle; capture combinational outputs.
    task automatic send(input bit wr, input int a, input int id, input int tag, input bit rdy);
        @(negedge clk);
        cmd_valid = 1; cmd_write = wr; cmd_addr = AW'(a);
        cmd_id = IW'(id); cmd_tag = TW'(tag); mem_ready = rdy;
        #2;
        got_mv = mem_valid; got_cr = cmd_ready; got_ma = mem_addr;
        @(negedge clk);
        cmd_valid = 0; mem_ready = 0;
    endtask

    task automatic clear_err();
        @(negedge clk); aerr_clr = 1;
        @(negedge clk); aerr_clr = 0;
    endtask

    task automatic t_reset();
        chk("R7 raw after reset", int_raw, 0);
        chk("R8 irq after reset", irq, 0);
        chk("R9 log after reset", log_addr, 0);
        chk("R4 no wr rsp after reset", wr_rsp_valid, 0);
    endtask

    task automatic t_region_quiet();
        set_cfg(8, 8, 0);
        send(1, 16'hFFFF, 1, 1, 1);
        chk("R1 equal idx write forwarded", got_mv, 1);
        chk("R1 equal idx no error", int_raw[1], 0);
        set_cfg(8, 3, 1);
        send(0, 16'hF000, 1, 1, 0);
        chk("R1 small region read forwarded", got_mv, 1);
        chk("R5 ready follows memory", got_cr, 0);
        chk("R1 small region no error", int_raw[1], 0);
    endtask

    task automatic t_limit();
        set_cfg(8, 9, 0);
        send(1, 4095, 2, 0, 1);
        chk("R2 below limit forwarded", got_mv, !exp_bad(4095, 8, 9, 0));
        chk("R5 address passes", got_ma, 4095);
        chk("R2 below limit no error", int_raw[1], 0);
        send(1, 4096, 3, 5, 0);
        chk("R2 at limit write held back", got_mv, !exp_bad(4096, 8, 9, 0));
        chk("R4 flagged write accepted", got_cr, 1);
        chk("R4 error response valid", wr_rsp_valid, 1);
        chk("R4 error response flag", wr_rsp_err, 1);
        chk("R4 error response tag", wr_rsp_tag, 5);
        chk("R7 raw set", int_raw, 2);
        chk("R9 first log addr", log_addr, 4096);
        chk("R9 first log id", log_id, 3);
    endtask

    task automatic t_log_first();
        send(0, 16'h8000, 9, 2, 1);
        chk("R9 log keeps first addr", log_addr, 4096);
        chk("R9 log keeps first id", log_id, 3);
        chk("R7 raw still set", int_raw[1], 1);
        clear_err();
        chk("R7 raw cleared", int_raw[1], 0);
        send(0, 16'h9000, 7, 2, 1);
        chk("R9 log recaptured addr", log_addr, 16'h9000);
        chk("R9 log recaptured id", log_id, 7);
        clear_err();
    endtask

    task automatic t_ecc();
        set_cfg(8, 9, 1);
        send(1, 3640, 1, 0, 1);
        chk("R3 ecc last valid addr", got_mv, !exp_bad(3640, 8, 9, 1));
        chk("R3 ecc last valid no error", int_raw[1], 0);
        send(1, 3641, 4, 3, 1);
        chk("R3 ecc first bad addr", got_mv, !exp_bad(3641, 8, 9, 1));
        chk("R3 ecc error raised", int_raw[1], 1);
        clear_err();
        set_cfg(8, 9, 0);
        send(1, 4000, 1, 0, 1);
        chk("R3 same addr fine without ecc", got_mv, 1);
        chk("R3 no error without ecc", int_raw[1], 0);
    endtask

    task automatic t_wr_rsp();
        set_cfg(8, 9, 0);
        @(negedge clk);
        cmd_valid = 1; cmd_write = 1; cmd_addr = 16'hA000; cmd_tag = 6; mem_ready = 1;
        #2 chk("R4 flagged write not on memory", mem_valid, 0);
        @(negedge clk);
        cmd_valid = 0; mem_wr_rsp_valid = 1; mem_wr_rsp_tag = 2;
        #2;
        chk("R4 local response first tag", wr_rsp_tag, 6);
        chk("R4 memory response held", mem_wr_rsp_ready, 0);
        chk("R4 local response err", wr_rsp_err, 1);
        @(negedge clk);
        #2;
        chk("R5 memory response tag", wr_rsp_tag, 2);
        chk("R5 memory response ok", wr_rsp_err, 0);
        chk("R5 memory response taken", mem_wr_rsp_ready, 1);
        @(negedge clk);
        mem_wr_rsp_valid = 0;
        clear_err();
    endtask

    task automatic t_read();
        set_cfg(8, 9, 0);
        send(0, 100, 1, 1, 1);
        send(0, 5000, 1, 2, 1);
        chk("R6 flagged read forwarded", got_mv, 1);
        @(negedge clk);
        mem_rd_valid = 1; mem_rd_tag = 2; mem_rd_data = 16'hBEEF; mem_rd_last = 0;
        #2;
        chk("R6 flagged beat zeroed", rd_rsp_data, 0);
        chk("R6 flagged beat err", rd_rsp_err, 1);
        @(negedge clk);
        mem_rd_tag = 1; mem_rd_data = 16'h1234; mem_rd_last = 1;
        #2;
        chk("R6 good beat data", rd_rsp_data, 16'h1234);
        chk("R6 good beat ok", rd_rsp_err, 0);
        chk("R6 last passes", rd_rsp_last, 1);
        @(negedge clk);
        mem_rd_tag = 2; mem_rd_data = 16'h5555;
        #2 chk("R6 second flagged beat zeroed", rd_rsp_data, 0);
        @(negedge clk);
        mem_rd_valid = 0; mem_rd_last = 0;
    endtask

    task automatic t_irq();
        @(negedge clk); irq_en = 0;
        #2 chk("R8 raw set before irq test", int_raw[1], 1);
        chk("R8 irq masked", irq, 0);
        @(negedge clk); irq_en = 1;
        #2 chk("R8 irq raised", irq, 1);
        clear_err();
        chk("R8 irq drops on clear", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2 t_reset();
        t_region_quiet();
        t_limit();
        t_log_first();
        t_ecc();
        t_wr_rsp();
        t_read();
        t_irq();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule